// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port for a microcontroller, working like the shift-register mode of a classic UART. One bidirectional data pin carries the bits, least significant first. A second pin drives the shift clock. The shift clock idles high. Each clock period is a high phase followed by a low phase, and each phase lasts one pulse of the baud-enable input `tick`.

Software drives the block through two registers. The first is a five-bit control register with the fields {mode[1:0] at bits 4:3, rx_en at bit 2, tx_flag at bit 1, rx_flag at bit 0}. The second is a data buffer: a write to it starts a transmit, and a read of it returns the last received byte. A receive starts when the control register is written with mode 00, rx_en set and rx_flag clear. Both completion flags stay set until software writes them to zero. Only mode 00 is served. The other mode codes leave the port idle.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `sclk_o`=1, `sdat_o`=1, `sdat_oe`=1, `busy`=0 and `ctrl_rdata`=0. While idle, `sclk_o` and `sdat_o` stay high and the data pin is driven.
- R2: A write to the data buffer while idle with control bits 4:3 = 00 starts a transmit. `busy` is 1 in the next cycle, and bit 0 of the written byte is on `sdat_o`.
- R3: Bit k of the transmitted byte is on `sdat_o` during shift-clock period k, counting from 0. A period is one tick high followed by one tick low, so falling edges of `sclk_o` are two tick intervals apart.
- R4: On the rising edge that ends the eighth period, `busy` clears, `sdat_o` returns to 1 and is driven, and the transmit flag (control bit 1) is set.
- R5: A control write of mode 00 with bit 2 (rx_en) = 1 and bit 0 (rx_flag) = 0, made while idle, starts a receive. The data pin is released (`sdat_oe`=0) only while receiving.
- R6: A receive samples `sdat_i` at each rising edge of `sclk_o`. The first sample becomes bit 0. After the eighth sample the byte appears on `buf_rdata` and the receive flag (control bit 0) is set.
- R7: Both flags hold their value until a control write changes them.
- R8: A control write with rx_flag = 1 or with rx_en = 0 does not start a receive.
- R9: A data-buffer write made while `busy` is 1 is ignored. The byte in flight and its bit timing are unchanged.
- R10: A data-buffer write while control bits 4:3 are not 00 is ignored. `busy` and `sclk_o` stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Baud enable, one pulse per half shift-clock period |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control write value {mode[1:0], rx_en, tx_flag, rx_flag} |
| ctrl_rdata | output | 5 | Control register contents |
| buf_we | input | 1 | Data buffer write strobe (starts a transmit) |
| buf_wdata | input | DATA_W | Byte to transmit |
| buf_rdata | output | DATA_W | Last received byte |
| busy | output | 1 | Transfer in progress |
| sdat_i | input | 1 | Data pin input |
| sdat_o | output | 1 | Data pin output value |
| sdat_oe | output | 1 | Data pin output enable |
| sclk_o | output | 1 | Shift clock output |

## Verification
A start is visible one cycle after its write strobe. After that, every pin change falls on the clock edge where `tick` is seen. Data moves in the edge that follows a high-to-low-to-high shift-clock cycle, and the flag and buffer update on the eighth rising edge itself. For this reason the bench waits on the edges of `sclk_o` and then reads at the following falling edge of `clk`, so each result is read one half cycle after the register that produces it. Received bits are applied just after each falling shift-clock edge, which leaves a full tick interval for the input synchronizer before the sampling edge. The gap between falling edges is counted in clock cycles and compared against two tick intervals.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   typedef enum logic [1:0] {
      MODE_SHIFT = 2'b00,
      MODE_A1    = 2'b01,
      MODE_A2    = 2'b10,
      MODE_A3    = 2'b11
   } ssp_mode_e;

   typedef struct packed {
      ssp_mode_e mode;
      logic      rx_en;
      logic      tx_flag;
      logic      rx_flag;
   } ssp_ctrl_t;

   localparam int CTRL_W = $bits(ssp_ctrl_t);
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
   import ssp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ctrl_we,
   input  ssp_ctrl_t ctrl_wdata,
   input  logic      buf_we,
   input  logic      busy,
   input  logic      done,
   input  logic      done_rx,
   output ssp_ctrl_t ctrl_q,
   output logic      start_tx,
   output logic      start_rx
);
   always_comb begin
      start_tx = buf_we && (ctrl_q.mode == MODE_SHIFT) && !busy;
      start_rx = ctrl_we && (ctrl_wdata.mode == MODE_SHIFT) && ctrl_wdata.rx_en
                 && !ctrl_wdata.rx_flag && !busy && !start_tx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (ctrl_we) ctrl_q <= ctrl_wdata;
         if (done) begin
            if (done_rx) ctrl_q.rx_flag <= 1'b1;
            else         ctrl_q.tx_flag <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/ssp_seq.sv
module ssp_seq #(
   parameter int DATA_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start_tx,
   input  logic start_rx,
   output logic busy,
   output logic rx_mode,
   output logic low_phase,
   output logic rise,
   output logic done
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      rise = busy && tick && low_phase;
      done = rise && (cnt_q == LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         rx_mode   <= 1'b0;
         low_phase <= 1'b0;
         cnt_q     <= '0;
      end else if (start_tx || start_rx) begin
         busy      <= 1'b1;
         rx_mode   <= start_rx;
         low_phase <= 1'b0;
         cnt_q     <= '0;
      end else if (busy && tick) begin
         if (!low_phase) begin
            low_phase <= 1'b1;
         end else begin
            low_phase <= 1'b0;
            if (cnt_q == LAST) busy  <= 1'b0;
            else               cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              rise,
   input  logic              done,
   input  logic              rx_mode,
   input  logic              sdat_i,
   output logic              tx_bit,
   output logic [DATA_W-1:0] rx_data
);
   logic              smp;
   logic [DATA_W-1:0] sreg_q;
   logic [DATA_W-1:0] shifted;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign smp = sdat_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], sdat_i};
         end
         assign smp = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_comb begin
      shifted = {(rx_mode ? smp : 1'b1), sreg_q[DATA_W-1:1]};
      tx_bit  = sreg_q[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q  <= '1;
         rx_data <= '0;
      end else begin
         if (load)      sreg_q <= load_data;
         else if (rise) sreg_q <= shifted;
         if (done && rx_mode) rx_data <= shifted;
      end
   end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
   import ssp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ctrl_we,
   input  logic [4:0]        ctrl_wdata,
   output logic [4:0]        ctrl_rdata,
   input  logic              buf_we,
   input  logic [DATA_W-1:0] buf_wdata,
   output logic [DATA_W-1:0] buf_rdata,
   output logic              busy,
   input  logic              sdat_i,
   output logic              sdat_o,
   output logic              sdat_oe,
   output logic              sclk_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("sync_shift_port: DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("sync_shift_port: SYNC_STAGES must be 0..4");
   end
   if (CTRL_W != 5) begin : g_bad_ctrl
      $error("sync_shift_port: control layout must be 5 bits");
   end

   ssp_ctrl_t ctrl_q;
   logic start_tx, start_rx, rx_mode, low_phase, rise, done, tx_bit;

   ssp_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (ctrl_we),
      .ctrl_wdata(ssp_ctrl_t'(ctrl_wdata)),
      .buf_we    (buf_we),
      .busy      (busy),
      .done      (done),
      .done_rx   (rx_mode),
      .ctrl_q    (ctrl_q),
      .start_tx  (start_tx),
      .start_rx  (start_rx)
   );

   ssp_seq #(.DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .start_tx (start_tx),
      .start_rx (start_rx),
      .busy     (busy),
      .rx_mode  (rx_mode),
      .low_phase(low_phase),
      .rise     (rise),
      .done     (done)
   );

   ssp_shifter #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_tx),
      .load_data(buf_wdata),
      .rise     (rise),
      .done     (done),
      .rx_mode  (rx_mode),
      .sdat_i   (sdat_i),
      .tx_bit   (tx_bit),
      .rx_data  (buf_rdata)
   );

   always_comb begin
      ctrl_rdata = ctrl_q;
      sclk_o     = !(busy && low_phase);
      sdat_oe    = !(busy && rx_mode);
      sdat_o     = (busy && !rx_mode) ? tx_bit : 1'b1;
   end
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       sclk_o,
   input logic       sdat_o,
   input logic       sdat_oe,
   input logic       buf_we,
   input logic       ctrl_we,
   input logic [4:0] ctrl_rdata
);
   // R1
   idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk_o && sdat_o && sdat_oe));

   // R2
   tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && !busy && ctrl_rdata[4:3] == 2'b00) |=> busy);

   // R4
   tx_flag_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ctrl_rdata[1]) && !$past(ctrl_we)) |-> $fell(busy));

   // R5
   pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sdat_oe |-> busy);

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rdata[1] && !ctrl_we) |=> ctrl_rdata[1]);

   // R10
   other_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rdata[4:3] != 2'b00 && !busy) |=> !busy);
endmodule

bind sync_shift_port ssp_port_chk u_port_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .sclk_o    (sclk_o),
   .sdat_o    (sdat_o),
   .sdat_oe   (sdat_oe),
   .buf_we    (buf_we),
   .ctrl_we   (ctrl_we),
   .ctrl_rdata(ctrl_rdata)
);

// File: tb/tb_sync_shift_port.sv
module tb_sync_shift_port;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          ctrl_we = 1'b0;
   logic [4:0]    ctrl_wdata = '0;
   logic [4:0]    ctrl_rdata;
   logic          buf_we = 1'b0;
   logic [DW-1:0] buf_wdata = '0;
   logic [DW-1:0] buf_rdata;
   logic          busy, sdat_o, sdat_oe, sclk_o;
   logic          sdat_i = 1'b1;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit ended = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sync_shift_port #(.DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
      .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
      .busy(busy), .sdat_i(sdat_i), .sdat_o(sdat_o), .sdat_oe(sdat_oe),
      .sclk_o(sclk_o)
   );

   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         div  = (div + 1) % 4;
         tick = (div == 0);
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic write_ctrl(input logic [4:0] v);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic write_buf(input logic [DW-1:0] v);
      @(negedge clk);
      buf_we = 1'b1; buf_wdata = v;
      @(negedge clk);
      buf_we = 1'b0;
   endtask

   task automatic test_reset();
      check(sclk_o == 1'b1, "R1 sclk", sclk_o, 1);
      check(sdat_o == 1'b1 && sdat_oe == 1'b1, "R1 pin", {sdat_o, sdat_oe}, 3);
      check(busy == 1'b0, "R1 busy", busy, 0);
      check(ctrl_rdata == 5'd0, "R1 ctrl", ctrl_rdata, 0);
   endtask

   task automatic test_tx(input logic [DW-1:0] d, input bit poke);
      int last_fall = 0;
      write_buf(d);
      check(busy == 1'b1, "R2 busy", busy, 1);
      check(sdat_o == d[0], "R2 first bit", sdat_o, d[0]);
      for (int k = 0; k < DW; k++) begin
         @(negedge sclk_o);
         @(negedge clk);
         check(sdat_o == d[k], k > 0 ? "R3 bit / R9 intact" : "R3 bit", sdat_o, d[k]);
         if (k > 0) check(cyc - last_fall == 8, "R3 period", cyc - last_fall, 8);
         last_fall = cyc;
         if (poke && k == 3) write_buf(~d);
      end
      @(posedge sclk_o);
      @(negedge clk);
      check(busy == 1'b0, "R4 busy", busy, 0);
      check(sdat_o == 1'b1 && sdat_oe == 1'b1, "R4 pin high", {sdat_o, sdat_oe}, 3);
      check(ctrl_rdata[1] == 1'b1, "R4 tx flag", ctrl_rdata[1], 1);
      repeat (20) @(negedge clk);
      check(ctrl_rdata[1] == 1'b1, "R7 tx flag held", ctrl_rdata[1], 1);
      write_ctrl(5'b00000);
      check(ctrl_rdata[1] == 1'b0, "R7 tx flag cleared", ctrl_rdata[1], 0);
   endtask

   task automatic test_rx(input logic [DW-1:0] d);
      write_ctrl(5'b00100);
      check(busy == 1'b1 && sdat_oe == 1'b0, "R5 start/release", {busy, sdat_oe}, 2);
      for (int k = 0; k < DW; k++) begin
         @(negedge sclk_o);
         @(negedge clk);
         sdat_i = d[k];
      end
      @(posedge sclk_o);
      @(negedge clk);
      sdat_i = 1'b1;
      check(buf_rdata == d, "R6 rx byte", buf_rdata, d);
      check(ctrl_rdata[0] == 1'b1, "R6 rx flag", ctrl_rdata[0], 1);
      check(sdat_oe == 1'b1 && busy == 1'b0, "R5 pin driven after rx", {sdat_oe, busy}, 2);
      repeat (20) @(negedge clk);
      check(ctrl_rdata[0] == 1'b1, "R7 rx flag held", ctrl_rdata[0], 1);
   endtask

   task automatic test_no_rx();
      bit stayed = 1;
      write_ctrl(5'b00101);
      repeat (20) begin
         @(negedge clk);
         if (busy || !sdat_oe) stayed = 0;
      end
      check(stayed, "R8 rx_flag set blocks rx", stayed, 1);
      stayed = 1;
      write_ctrl(5'b00000);
      repeat (20) begin
         @(negedge clk);
         if (busy || !sdat_oe) stayed = 0;
      end
      check(stayed, "R8 rx_en clear blocks rx", stayed, 1);
   endtask

   task automatic test_other_mode();
      bit stayed = 1;
      write_ctrl(5'b01000);
      write_buf(8'h3C);
      repeat (20) begin
         @(negedge clk);
         if (busy || !sclk_o) stayed = 0;
      end
      check(stayed, "R10 write ignored", stayed, 1);
      write_ctrl(5'b00000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_tx(8'hA5, 1'b0);
      test_tx(8'h01, 1'b1);
      test_rx(8'h96);
      test_rx(8'h7E);
      test_no_rx();
      test_other_mode();
      test_tx(8'h80, 1'b0);
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
   end
endmodule